// File: doc/BRIEF.md
# Multiplexer-Carry Ripple Adder

This block adds or subtracts two N-bit operands with a carry chain in which each bit is built from an XOR and a 2:1 multiplexer, not from a majority-gate full adder. Each bit forms a propagate term as the XOR of its operand bits. The bit's multiplexer, steered by that term, passes either the arriving carry or the second operand bit onward. The sum bit is the propagate term XORed with the arriving carry. The carry ripples from bit 0 upward through the multiplexers, a structure that maps straight onto the dedicated carry resources of programmable logic.

A mode pin selects addition or subtraction. When subtracting, the second operand is inverted and the chain's carry input is forced high, so the external carry pin plays no part. A signed overflow flag comes from the carries into and out of the top bit. Parameters add a register stage on the inputs, on the outputs, or on both, to meet timing. Each stage adds one cycle of latency and does not limit throughput.

Top module: `mux_carry_adder`

## Requirements
- R1: With the mode pin low (add), sum_o equals (x_i + y_i + cin_i) modulo 2^WIDTH, and cout_o equals bit WIDTH of that full sum.
- R2: In every bit cell, twice the cell's carry-out plus its sum bit equals x + y + carry-in for all eight input combinations, where carry-out is the arriving carry when x XOR y is 1 and the y bit otherwise.
- R3: With the mode pin high (subtract), sum_o equals (x_i - y_i) modulo 2^WIDTH and cout_o is 1 exactly when x_i >= y_i unsigned; cin_i has no effect in this mode.
- R4: ovf_o is 1 exactly when the two's-complement result (x+y+cin when adding, x-y when subtracting) lies outside the signed WIDTH-bit range.
- R5: A result appears IN_REG + OUT_REG clock cycles after its operands are presented, and a new operand set is accepted every cycle.
- R6: While rst is high, sum_o, cout_o and ovf_o are 0 whatever the inputs; after release, the outputs stay 0 until the first operands have passed through the pipeline.
- R7: A carry entering bit 0 travels the whole chain: all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand (subtrahend when subtracting) |
| cin_i | input | 1 | Carry input, used only when adding |
| sum_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Carry out of the top bit (1 = no borrow when subtracting) |
| ovf_o | output | 1 | Signed overflow |

## Verification
Three things can happen in the same cycle: the end-to-end carry ripple, a signed overflow, and a subtraction whose external carry pin is being driven. For example, subtracting with cin_i at 0 must still inject a carry, and that carry can ripple into the top bit just as overflow arises. A four-bit instance is driven through every combination of operands, carry pin and mode, so each such coincidence occurs. A 32-bit instance runs random operands with all-ones and equal-operand corners mixed in. A behavioural model computes each expected result from integer arithmetic, and every cycle the outputs are compared with the value the model queued two cycles earlier.

// File: rtl/madd_pkg.sv
package madd_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/mux_carry_cell.sv
module mux_carry_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic prop;

  assign prop = x ^ y;
  assign s    = prop ^ ci;
  // carry mux: propagate passes the arriving carry, otherwise y acts as generate
  assign co   = prop ? ci : y;

  // R2: per-cell arithmetic identity
  always_comb begin
    p_cell_identity_r2: assert ({co, s} == (2'(x) + 2'(y) + 2'(ci)))
      else $error("cell identity broken x=%b y=%b ci=%b", x, y, ci);
  end
endmodule

// File: rtl/mux_carry_chain.sv
module mux_carry_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c0,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;

  assign carry[0] = c0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    mux_carry_cell u_cell (
      .x  (a[i]),
      .y  (b[i]),
      .ci (carry[i]),
      .s  (sum[i]),
      .co (carry[i+1])
    );
  end

  assign cout = carry[WIDTH];
  assign ovf  = carry[MSB] ^ carry[WIDTH];
endmodule

// File: rtl/madd_stage.sv
module madd_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (EN) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end

    // R5: each stage delays by exactly one cycle
    p_stage_delay_r5: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (q == $past(d)))
      else $error("stage did not carry its input one cycle");
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/mux_carry_adder.sv
module mux_carry_adder
  import madd_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int INW  = 2 * WIDTH + 2;
  localparam int OUTW = WIDTH + 2;
  localparam int MSB  = WIDTH - 1;

  logic [INW-1:0]   in_d, in_q;
  logic [OUTW-1:0]  out_d, out_q;
  op_e              op;
  logic             cin_s, c0;
  logic [WIDTH-1:0] x_s, y_s, y_eff;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c, ovf_c;

  assign in_d = {sub_i, cin_i, x_i, y_i};

  madd_stage #(.W(INW), .EN(IN_REG)) u_in_stage (
    .clk (clk),
    .rst (rst),
    .d   (in_d),
    .q   (in_q)
  );

  assign op    = in_q[INW-1] ? OP_SUB : OP_ADD;
  assign cin_s = in_q[INW-2];
  assign x_s   = in_q[2*WIDTH-1:WIDTH];
  assign y_s   = in_q[WIDTH-1:0];

  // operand conditioning: subtract = add inverted y with a forced carry
  assign y_eff = (op == OP_SUB) ? ~y_s : y_s;
  assign c0    = (op == OP_SUB) ? 1'b1 : cin_s;

  mux_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .a    (x_s),
    .b    (y_eff),
    .c0   (c0),
    .sum  (sum_c),
    .cout (cout_c),
    .ovf  (ovf_c)
  );

  assign out_d = {ovf_c, cout_c, sum_c};

  madd_stage #(.W(OUTW), .EN(OUT_REG)) u_out_stage (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign sum_o  = out_q[WIDTH-1:0];
  assign cout_o = out_q[WIDTH];
  assign ovf_o  = out_q[WIDTH+1];

  // R1: add mode gives the full-width sum of the staged operands
  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |->
      ({cout_c, sum_c} == ((WIDTH+1)'(x_s) + (WIDTH+1)'(y_s) + (WIDTH+1)'(cin_s))))
    else $error("add result wrong");

  // R3: subtract mode gives the difference and the no-borrow flag
  p_sub_diff_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |-> ((sum_c == WIDTH'(x_s - y_s)) && (cout_c == (x_s >= y_s))))
    else $error("subtract result wrong");

  // R4: overflow judged by operand and result signs
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_c == ((x_s[MSB] == y_eff[MSB]) && (sum_c[MSB] != x_s[MSB])))
    else $error("overflow flag disagrees with sign rule");
endmodule

// File: tb/tb_mux_carry_adder.sv
module tb_mux_carry_adder;
  localparam int NS  = 4;
  localparam int NW  = 32;
  localparam int LAT = 2;

  typedef struct {
    longint sum;
    bit     co;
    bit     ov;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          s_sub, s_cin, w_sub, w_cin;
  logic [NS-1:0] s_x, s_y, s_sum;
  logic [NW-1:0] w_x, w_y, w_sum;
  logic          s_co, s_ov, w_co, w_ov;

  int checks = 0;
  int fails  = 0;
  exp_t q_s[$];
  exp_t q_w[$];

  mux_carry_adder #(.WIDTH(NS), .IN_REG(1'b1), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .sub_i(s_sub), .x_i(s_x), .y_i(s_y), .cin_i(s_cin),
    .sum_o(s_sum), .cout_o(s_co), .ovf_o(s_ov));

  mux_carry_adder #(.WIDTH(NW), .IN_REG(1'b1), .OUT_REG(1'b1)) dut_wide (
    .clk(clk), .rst(rst), .sub_i(w_sub), .x_i(w_x), .y_i(w_y), .cin_i(w_cin),
    .sum_o(w_sum), .cout_o(w_co), .ovf_o(w_ov));

  function automatic exp_t model(int w, longint x, longint y, bit cin, bit sub, string tag);
    exp_t   r;
    longint m    = (64'sd1 <<< w) - 1;
    longint half = 64'sd1 <<< (w - 1);
    longint ye   = sub ? (~y & m) : y;
    longint c    = sub ? 1 : longint'(cin);
    longint full = x + ye + c;
    longint sx   = (x >= half) ? x - (64'sd1 <<< w) : x;
    longint sy   = (y >= half) ? y - (64'sd1 <<< w) : y;
    longint res  = sub ? (sx - sy) : (sx + sy + longint'(cin));
    r.sum = full & m;
    r.co  = ((full >>> w) & 1) != 0;
    r.ov  = (res >= half) || (res < -half);
    r.tag = tag;
    return r;
  endfunction

  task automatic judge(string tag, longint got_s, bit got_c, bit got_v, exp_t e);
    checks++;
    if (got_s != e.sum || got_c != e.co) begin
      fails++;
      $display("FAIL %s R5: sum/cout got %0h/%0b expected %0h/%0b", tag, got_s, got_c, e.sum, e.co);
    end
    checks++;
    if (got_v != e.ov) begin
      fails++;
      $display("FAIL R4 (%s): ovf got %0b expected %0b", tag, got_v, e.ov);
    end
  endtask

  // compare what left the pipeline, then drive the next operands
  task automatic step(bit ssub, longint sx, longint sy, bit scin, string stag,
                      bit wsub, longint wx, longint wy, bit wcin, string wtag);
    exp_t e;
    @(negedge clk);
    if (q_s.size() == LAT) begin
      e = q_s.pop_front();
      judge(e.tag, longint'(s_sum), s_co, s_ov, e);
    end
    if (q_w.size() == LAT) begin
      e = q_w.pop_front();
      judge(e.tag, longint'(w_sum), w_co, w_ov, e);
    end
    s_sub = ssub; s_x = NS'(sx); s_y = NS'(sy); s_cin = scin;
    w_sub = wsub; w_x = NW'(wx); w_y = NW'(wy); w_cin = wcin;
    q_s.push_back(model(NS, sx, sy, scin, ssub, stag));
    q_w.push_back(model(NW, wx, wy, wcin, wsub, wtag));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R6: outputs held at zero under reset while inputs are busy
    s_sub = 1'b0; s_x = '1; s_y = '1; s_cin = 1'b1;
    w_sub = 1'b0; w_x = '1; w_y = '1; w_cin = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (s_sum != '0 || s_co || s_ov || w_sum != '0 || w_co || w_ov) begin
        fails++;
        $display("FAIL R6: got %0h/%0b/%0b %0h/%0b/%0b expected all zero",
                 s_sum, s_co, s_ov, w_sum, w_co, w_ov);
      end
    end
    rst = 1'b0;
    // R6: pipeline drained to zero right after release
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (s_sum != '0 || s_co || s_ov || w_sum != '0 || w_co || w_ov) begin
      fails++;
      $display("FAIL R6: after release got %0h/%0b %0h/%0b expected zero",
               s_sum, s_co, w_sum, w_co);
    end

    // exhaustive small width, random wide width in the same cycles
    for (int i = 0; i < 1024; i++) begin
      bit     ssub = i[9];
      bit     scin = i[8];
      longint sx   = longint'(i[3:0]);
      longint sy   = longint'(i[7:4]);
      string  st;
      bit     wsub;
      bit     wcin;
      longint wx, wy;
      string  wt;
      if (!ssub && sx == 15 && sy == 0 && scin) st = "R7";
      else if (ssub) st = "R3";
      else st = "R1/R2";
      wsub = $urandom_range(0, 1) != 0;
      wcin = $urandom_range(0, 1) != 0;
      wx = longint'($urandom);
      wy = longint'($urandom);
      case (i % 8)
        1: begin wsub = 1'b0; wx = 64'hFFFF_FFFF; wy = 0; wcin = 1'b1; end // ripple end to end
        3: begin wsub = 1'b1; wy = wx; end                                 // equal operands
        5: begin wsub = 1'b1; wx = 64'h8000_0000; wy = 1; wcin = 1'b0; end // signed overflow
        default: ;
      endcase
      if (i % 8 == 1) wt = "R7";
      else if (wsub) wt = "R3";
      else wt = "R1";
      step(ssub, sx, sy, scin, st, wsub, wx, wy, wcin, wt);
    end
    // R3: carry pin toggled while subtracting must not matter
    step(1'b1, 5, 9, 1'b0, "R3", 1'b1, 100, 200, 1'b0, "R3");
    step(1'b1, 5, 9, 1'b1, "R3", 1'b1, 100, 200, 1'b1, "R3");
    // R5: back-to-back distinct results, then drain
    step(1'b0, 7, 8, 1'b0, "R1", 1'b0, 64'h7FFF_FFFF, 1, 1'b0, "R1");
    step(1'b0, 0, 0, 1'b0, "R1", 1'b0, 0, 0, 1'b0, "R1");
    step(1'b0, 0, 0, 1'b0, "R1", 1'b0, 0, 0, 1'b0, "R1");
    step(1'b0, 0, 0, 1'b0, "R1", 1'b0, 0, 0, 1'b0, "R1");
    summary();
    $finish;
  end
endmodule